// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block sequences the conversions of a multi-channel analog front end. Software keeps a channel mask through two write ports. A set port writes ones that turn channels on, and a clear port writes ones that turn channels off. A single start pulse makes the sequencer latch the mask and walk through every enabled channel from the lowest index upward. Disabled channels are skipped without using any cycles.

For each channel the sequencer raises a convert request that carries the channel index. It holds that request until the converter answers with a done strobe and a data word. The result then leaves on a valid/data stream tagged with its channel number, so the stream holds entries only for enabled channels. After the last channel, a one-cycle sequence-done pulse tells the trigger logic that it may start again.

In dual-trigger mode the highest-index channel is left out of the normal scan. It is converted only when its own trigger input fires, so it can run at an independent rate. A top trigger that arrives during a scan is held pending and is served right after the scan ends.

Top module: `adc_scan_seq`

## Requirements
- R1: A set write ORs its bits into the mask, and a clear write removes its bits. When both target the same bit in one cycle, the clear wins. The new mask appears on `mask_o` one cycle after the write.
- R2: A start accepted while idle latches the mask. The request for the lowest enabled channel appears one cycle later. The following channels are requested in strictly ascending index order, and disabled channels are skipped.
- R3: `conv_req_o` stays high with a stable `conv_ch_o` until `conv_done_i` is sampled. One cycle after that, `res_valid_o` pulses with `res_ch_o` equal to the converted channel and `res_data_o` equal to the sampled `conv_data_i`. The request for the next channel appears in that same cycle.
- R4: `seq_done_o` is a one-cycle pulse in the same cycle as the last result of a normal scan. After it, the request is low unless a top conversion follows.
- R5: A start with no channel selected makes `seq_done_o` pulse in the next cycle. No request is issued and `busy_o` stays low.
- R6: Mask writes made during a scan do not change the set of channels in that scan. They show on `mask_o` and take effect at the next start.
- R7: A start that arrives while `busy_o` is high is ignored. No further scan follows.
- R8: With `dual_mode_i` = 1, channel NUM_CH-1 is never requested by a normal scan. A top trigger taken while idle with that channel enabled gives a request for channel NUM_CH-1 two cycles later. This produces exactly one result and no `seq_done_o`.
- R9: A top trigger taken during a normal scan is held pending. The request for channel NUM_CH-1 appears in the same cycle as that scan's `seq_done_o`.
- R10: A top trigger has no effect when `dual_mode_i` = 0, or when the mask bit of channel NUM_CH-1 is clear. In both cases no request and no result follow. With `dual_mode_i` = 0, channel NUM_CH-1 is part of the normal scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_set_wr_i | input | 1 | Strobe for a mask set write |
| en_set_bits_i | input | NUM_CH | Ones mark the channels to enable |
| en_clr_wr_i | input | 1 | Strobe for a mask clear write |
| en_clr_bits_i | input | NUM_CH | Ones mark the channels to disable |
| dual_mode_i | input | 1 | 1: the top channel is served only by its own trigger |
| start_i | input | 1 | Start pulse for a normal scan |
| top_trig_i | input | 1 | Trigger pulse for the top channel |
| conv_done_i | input | 1 | Converter finished the requested channel |
| conv_data_i | input | DATA_W | Conversion result, valid with conv_done_i |
| mask_o | output | NUM_CH | Current channel enable mask |
| busy_o | output | 1 | A conversion is in progress |
| conv_req_o | output | 1 | Convert request |
| conv_ch_o | output | log2(NUM_CH) | Channel index of the request |
| res_valid_o | output | 1 | Result strobe |
| res_ch_o | output | log2(NUM_CH) | Channel of the result |
| res_data_o | output | DATA_W | Result data |
| seq_done_o | output | 1 | Normal scan finished |

## Verification
Every output of this block is registered, so each result has a fixed due cycle. A mask write shows one cycle after it is made. The first request follows a start by one cycle, and a top request follows its trigger by two. A result, the next request and the done pulse all follow the converter's done strobe by one cycle. The bench plays the converter itself and drives inputs and samples outputs only on falling edges. At every falling edge of a scan it compares the request, channel, result and done outputs with the list it builds from its own mask model. It repeats this over random converter latencies, random masks and both trigger modes.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int unsigned NUM_CH_DEF = 8;
    localparam int unsigned DATA_W_DEF = 12;

    typedef enum logic {
        ST_IDLE,
        ST_CONV
    } scan_state_e;

    // Kind of conversion currently in flight
    typedef enum logic {
        JOB_SCAN,
        JOB_TOP
    } job_kind_e;

    // Index of the lowest set bit (0 when empty); supports up to 32 channels
    function automatic int unsigned first_set(input logic [31:0] v);
        int unsigned idx;
        idx = 0;
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) idx = i;
        end
        return idx;
    endfunction

endpackage

// File: rtl/adc_chan_mask.sv
module adc_chan_mask #(
    parameter int unsigned NUM_CH = adc_scan_pkg::NUM_CH_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_wr_i,
    input  logic [NUM_CH-1:0] set_bits_i,
    input  logic              clr_wr_i,
    input  logic [NUM_CH-1:0] clr_bits_i,
    output logic [NUM_CH-1:0] mask_o
);

    logic [NUM_CH-1:0] set_eff;
    logic [NUM_CH-1:0] clr_eff;

    assign set_eff = set_wr_i ? set_bits_i : '0;
    assign clr_eff = clr_wr_i ? clr_bits_i : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_o <= '0;
        end else begin
            mask_o <= (mask_o | set_eff) & ~clr_eff;
        end
    end

    // R1
    mask_clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
        clr_wr_i |=> ((mask_o & $past(clr_bits_i)) == '0));

    // R1
    mask_set_chk: assert property (@(posedge clk) disable iff (rst)
        (set_wr_i && !clr_wr_i) |=> ((mask_o & $past(set_bits_i)) == $past(set_bits_i)));

endmodule

// File: rtl/adc_top_trig.sv
module adc_top_trig (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    input  logic dual_i,
    input  logic top_en_i,
    input  logic ack_i,
    output logic pend_o
);

    logic take;

    assign take = trig_i && dual_i && top_en_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_o <= 1'b0;
        end else if (take) begin
            pend_o <= 1'b1;
        end else if (ack_i) begin
            pend_o <= 1'b0;
        end
    end

    // R9
    top_pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_o && !ack_i) |=> pend_o);

    // R10
    top_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!pend_o && !dual_i) |=> !pend_o);

endmodule

// File: rtl/adc_scan_engine.sv
module adc_scan_engine
    import adc_scan_pkg::*;
#(
    parameter int unsigned NUM_CH = NUM_CH_DEF,
    parameter int unsigned DATA_W = DATA_W_DEF,
    localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] mask_i,
    input  logic              dual_i,
    input  logic              start_i,
    input  logic              top_pend_i,
    output logic              top_ack_o,
    input  logic              conv_done_i,
    input  logic [DATA_W-1:0] conv_data_i,
    output logic              busy_o,
    output logic              conv_req_o,
    output logic [CH_W-1:0]   conv_ch_o,
    output logic              res_valid_o,
    output logic [CH_W-1:0]   res_ch_o,
    output logic [DATA_W-1:0] res_data_o,
    output logic              seq_done_o
);

    localparam logic [CH_W-1:0]   TOP_CH  = CH_W'(NUM_CH - 1);
    localparam logic [NUM_CH-1:0] TOP_BIT = NUM_CH'(1) << (NUM_CH - 1);

    scan_state_e       state_q;
    job_kind_e         job_q;
    logic [NUM_CH-1:0] pend_q;
    logic [CH_W-1:0]   cur_ch_q;
    logic              excl_top_q;
    logic [NUM_CH-1:0] scan_sel;
    logic              idle_top_go;
    logic              tail_top_go;
    logic              last_done;

    assign scan_sel    = mask_i & ~(dual_i ? TOP_BIT : '0);
    assign last_done   = (state_q == ST_CONV) && conv_done_i && (pend_q == '0);
    assign idle_top_go = (state_q == ST_IDLE) && !start_i && top_pend_i;
    assign tail_top_go = last_done && top_pend_i;
    assign top_ack_o   = idle_top_go || tail_top_go;

    assign busy_o     = (state_q == ST_CONV);
    assign conv_req_o = (state_q == ST_CONV);
    assign conv_ch_o  = cur_ch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            job_q       <= JOB_SCAN;
            pend_q      <= '0;
            cur_ch_q    <= '0;
            excl_top_q  <= 1'b0;
            res_valid_o <= 1'b0;
            res_ch_o    <= '0;
            res_data_o  <= '0;
            seq_done_o  <= 1'b0;
        end else begin
            res_valid_o <= 1'b0;
            seq_done_o  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        excl_top_q <= dual_i;
                        if (scan_sel == '0) begin
                            seq_done_o <= 1'b1;
                        end else begin
                            cur_ch_q <= CH_W'(first_set(32'(scan_sel)));
                            pend_q   <= scan_sel & (scan_sel - NUM_CH'(1));
                            job_q    <= JOB_SCAN;
                            state_q  <= ST_CONV;
                        end
                    end else if (top_pend_i) begin
                        cur_ch_q <= TOP_CH;
                        pend_q   <= '0;
                        job_q    <= JOB_TOP;
                        state_q  <= ST_CONV;
                    end
                end
                ST_CONV: begin
                    if (conv_done_i) begin
                        res_valid_o <= 1'b1;
                        res_ch_o    <= cur_ch_q;
                        res_data_o  <= conv_data_i;
                        if (pend_q != '0) begin
                            cur_ch_q <= CH_W'(first_set(32'(pend_q)));
                            pend_q   <= pend_q & (pend_q - NUM_CH'(1));
                        end else begin
                            if (job_q == JOB_SCAN) seq_done_o <= 1'b1;
                            if (top_pend_i) begin
                                cur_ch_q <= TOP_CH;
                                job_q    <= JOB_TOP;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_req_o && !conv_done_i) |=> (conv_req_o && $stable(conv_ch_o)));

    // R3
    res_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |-> $past(conv_req_o && conv_done_i));

    // R2
    ascend_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_req_o && conv_done_i && (pend_q != '0)) |=>
            (conv_req_o && (conv_ch_o > $past(conv_ch_o))));

    // R8
    top_excluded_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_req_o && (job_q == JOB_SCAN) && excl_top_q) |-> (conv_ch_o != TOP_CH));

    // R4
    done_then_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        seq_done_o |-> (!conv_req_o || (job_q == JOB_TOP)));

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
    parameter int unsigned NUM_CH = adc_scan_pkg::NUM_CH_DEF,
    parameter int unsigned DATA_W = adc_scan_pkg::DATA_W_DEF,
    localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_set_wr_i,
    input  logic [NUM_CH-1:0] en_set_bits_i,
    input  logic              en_clr_wr_i,
    input  logic [NUM_CH-1:0] en_clr_bits_i,
    input  logic              dual_mode_i,
    input  logic              start_i,
    input  logic              top_trig_i,
    input  logic              conv_done_i,
    input  logic [DATA_W-1:0] conv_data_i,
    output logic [NUM_CH-1:0] mask_o,
    output logic              busy_o,
    output logic              conv_req_o,
    output logic [CH_W-1:0]   conv_ch_o,
    output logic              res_valid_o,
    output logic [CH_W-1:0]   res_ch_o,
    output logic [DATA_W-1:0] res_data_o,
    output logic              seq_done_o
);

    logic top_pend;
    logic top_ack;

    adc_chan_mask #(.NUM_CH(NUM_CH)) i_mask (
        .clk        (clk),
        .rst        (rst),
        .set_wr_i   (en_set_wr_i),
        .set_bits_i (en_set_bits_i),
        .clr_wr_i   (en_clr_wr_i),
        .clr_bits_i (en_clr_bits_i),
        .mask_o     (mask_o)
    );

    adc_top_trig i_top (
        .clk      (clk),
        .rst      (rst),
        .trig_i   (top_trig_i),
        .dual_i   (dual_mode_i),
        .top_en_i (mask_o[NUM_CH-1]),
        .ack_i    (top_ack),
        .pend_o   (top_pend)
    );

    adc_scan_engine #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) i_engine (
        .clk         (clk),
        .rst         (rst),
        .mask_i      (mask_o),
        .dual_i      (dual_mode_i),
        .start_i     (start_i),
        .top_pend_i  (top_pend),
        .top_ack_o   (top_ack),
        .conv_done_i (conv_done_i),
        .conv_data_i (conv_data_i),
        .busy_o      (busy_o),
        .conv_req_o  (conv_req_o),
        .conv_ch_o   (conv_ch_o),
        .res_valid_o (res_valid_o),
        .res_ch_o    (res_ch_o),
        .res_data_o  (res_data_o),
        .seq_done_o  (seq_done_o)
    );

endmodule

// File: tb/test_adc_scan_seq.sv
`timescale 1ns/1ps
module test_adc_scan_seq;

    localparam int NCH = 8;
    localparam int DW  = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          set_wr = 1'b0, clr_wr = 1'b0;
    logic [NCH-1:0] set_bits = '0, clr_bits = '0;
    logic          dual = 1'b0, start = 1'b0, top_trig = 1'b0;
    logic          done = 1'b0;
    logic [DW-1:0] data = '0;
    logic [NCH-1:0] mask;
    logic          busy, req, res_valid, seq_done;
    logic [2:0]    ch, res_ch;
    logic [DW-1:0] res_data;

    int n_chk = 0;
    int n_bad = 0;
    int epoch = 0;
    bit finished = 0;
    logic [NCH-1:0] model_mask = '0;

    always #4 clk = ~clk;

    adc_scan_seq i_adc_scan_seq (
        .clk(clk), .rst(rst),
        .en_set_wr_i(set_wr), .en_set_bits_i(set_bits),
        .en_clr_wr_i(clr_wr), .en_clr_bits_i(clr_bits),
        .dual_mode_i(dual), .start_i(start), .top_trig_i(top_trig),
        .conv_done_i(done), .conv_data_i(data),
        .mask_o(mask), .busy_o(busy), .conv_req_o(req), .conv_ch_o(ch),
        .res_valid_o(res_valid), .res_ch_o(res_ch), .res_data_o(res_data),
        .seq_done_o(seq_done)
    );

    function automatic logic [DW-1:0] data_fn(input int c, input int e);
        return DW'((c * 37 + e * 101 + 5) & 12'hfff);
    endfunction

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic write_mask(input logic [NCH-1:0] s, input logic [NCH-1:0] c,
                              input bit do_s, input bit do_c);
        set_wr = do_s; set_bits = s; clr_wr = do_c; clr_bits = c;
        if (do_s) model_mask = model_mask | s;
        if (do_c) model_mask = model_mask & ~c;
        @(negedge clk);
        set_wr = 0; clr_wr = 0;
        chk(mask == model_mask, "R1 mask after write", mask, model_mask);
    endtask

    // Serve a top-channel request already visible at the current negedge
    task automatic serve_top();
        int lat;
        lat = $urandom_range(0, 3);
        repeat (lat) begin
            @(negedge clk);
            chk(req && ch == 3'd7, "R8 top request held", ch, 7);
        end
        done = 1; data = data_fn(7, epoch);
        @(negedge clk);
        done = 0;
        chk(res_valid && res_ch == 3'd7, "R8 top result channel", res_ch, 7);
        chk(res_data == data_fn(7, epoch), "R8 top result data", res_data, data_fn(7, epoch));
        chk(!seq_done, "R8 no done for top", seq_done, 0);
        chk(!req, "R8 idle after top", req, 0);
    endtask

    task automatic run_scan(input bit mid_clr_all, input bit mid_start, input bit mid_top);
        int lst[8];
        int n;
        int lat;
        bit follow;
        logic [NCH-1:0] sel;
        n = 0;
        sel = model_mask & ~(dual ? 8'h80 : 8'h00);
        for (int i = 0; i < NCH; i++) if (sel[i]) begin lst[n] = i; n++; end
        follow = mid_top && dual && model_mask[7];
        epoch++;
        start = 1;
        @(negedge clk);
        start = 0;
        if (n == 0) begin
            chk(seq_done, "R5 done after empty start", seq_done, 1);
            chk(!req && !busy, "R5 no request", req, 0);
            @(negedge clk);
            chk(!seq_done && !req, "R5 single pulse", seq_done, 0);
            return;
        end
        chk(req && int'(ch) == lst[0], "R2 first channel", ch, lst[0]);
        chk(busy && !seq_done, "R2 busy during scan", busy, 1);
        for (int k = 0; k < n; k++) begin
            lat = $urandom_range(0, 3);
            repeat (lat) begin
                @(negedge clk);
                chk(req && int'(ch) == lst[k], "R3 request held", ch, lst[k]);
                chk(!res_valid, "R3 no early result", res_valid, 0);
            end
            done = 1; data = data_fn(lst[k], epoch);
            if (k == 0) begin
                if (mid_clr_all) begin
                    clr_wr = 1; clr_bits = '1; model_mask = '0;
                end
                if (mid_start) start = 1;
                if (mid_top) top_trig = 1;
            end
            @(negedge clk);
            done = 0; clr_wr = 0; start = 0; top_trig = 0;
            chk(res_valid && int'(res_ch) == lst[k], "R3 result channel", res_ch, lst[k]);
            chk(res_data == data_fn(lst[k], epoch), "R3 result data", res_data, data_fn(lst[k], epoch));
            if (k < n - 1) begin
                chk(req && int'(ch) == lst[k+1], "R2 next channel", ch, lst[k+1]);
                chk(!seq_done, "R4 no early done", seq_done, 0);
            end else begin
                chk(seq_done, "R4 done with last result", seq_done, 1);
                if (follow) begin
                    chk(req && ch == 3'd7, "R9 queued top served", ch, 7);
                end else begin
                    chk(!req, "R4 request low after scan", req, 0);
                end
            end
        end
        if (follow) serve_top();
        if (mid_clr_all) chk(mask == model_mask, "R6 mask shows mid-scan write", mask, model_mask);
        @(negedge clk);
        chk(!req && !seq_done, "R7 no extra scan", req, 0);
    endtask

    task automatic top_alone(input bit expect_serve);
        epoch++;
        top_trig = 1;
        @(negedge clk);
        top_trig = 0;
        chk(!req, "R8 no request one cycle after trigger", req, 0);
        @(negedge clk);
        if (expect_serve) begin
            chk(req && ch == 3'd7, "R8 top request after two cycles", ch, 7);
            serve_top();
        end else begin
            chk(!req, "R10 top trigger ignored", req, 0);
            @(negedge clk);
            chk(!req && !res_valid, "R10 no result", res_valid, 0);
        end
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(mask == 0 && !req && !busy && !res_valid && !seq_done, "R1 reset state", mask, 0);

        // R1 directed
        write_mask(8'hA5, 8'h00, 1, 0);
        write_mask(8'h00, 8'h05, 0, 1);
        write_mask(8'h03, 8'h01, 1, 1);
        write_mask(8'h00, 8'hFF, 0, 1);

        // R5 empty mask
        run_scan(0, 0, 0);

        // R2 directed patterns, dual off (R10 top channel scanned)
        write_mask(8'h80, 8'h00, 1, 0);
        run_scan(0, 0, 0);
        write_mask(8'hFF, 8'h00, 1, 0);
        run_scan(0, 0, 0);
        write_mask(8'h00, 8'hFE, 0, 1);
        run_scan(0, 0, 0);

        // R10 top trigger with dual off
        write_mask(8'h80, 8'h00, 1, 0);
        top_alone(0);

        // R6 mid-scan clear, R7 mid-scan start
        write_mask(8'h5A, 8'h00, 1, 0);
        run_scan(1, 0, 0);
        write_mask(8'h66, 8'h00, 1, 0);
        run_scan(0, 1, 0);

        // R8 dual mode
        dual = 1;
        write_mask(8'hFF, 8'h00, 1, 0);
        run_scan(0, 0, 0);
        top_alone(1);
        // R9 queued top
        run_scan(0, 0, 1);
        // R8 only top enabled: normal scan empty
        write_mask(8'h00, 8'h7F, 0, 1);
        run_scan(0, 0, 0);
        // R10 top bit clear in dual mode
        write_mask(8'h0C, 8'h80, 1, 1);
        top_alone(0);

        // Random mix
        for (int it = 0; it < 40; it++) begin
            logic [NCH-1:0] s, c;
            s = NCH'($urandom);
            c = NCH'($urandom);
            dual = 1'($urandom_range(0, 1));
            write_mask(s, c, 1, ($urandom_range(0, 2) == 0));
            if ($urandom_range(0, 3) == 0) begin
                top_alone(dual && model_mask[7]);
            end else if ($countones(model_mask & ~(dual ? 8'h80 : 8'h00)) >= 2) begin
                run_scan(0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            end else begin
                run_scan(0, 0, 0);
            end
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule